// File: doc/BRIEF.md
# Wake Vote Power Controller

This block decides when a device may drop into deep sleep with its crystal oscillator turned off, and brings it back safely. While the device is awake and runs on the crystal, the controller counts consecutive idle cycles. When the count reaches a programmable limit, it turns the crystal off and selects the slow clock. The bus handshake is `busReq` and `busReady`. While the device is not awake on the crystal, `busReady` stays low, so any transfer is stalled.

A wake starts in either of two ways: a bus request, or a host vote held in a small vote register. First the crystal is enabled and a programmable stabilization count runs. Then the clock select moves to the crystal for one cycle. After that the bus is released and a status bit reports that the device is awake.

A held vote does more than wake the device. It also keeps the idle counter from running, so sleep cannot happen until the vote is cleared. A host that needs a read with predictable latency sets the vote, polls the status bit, and then issues the read.

Top module: `wake_vote_ctrl`

## Requirements
- R1: After reset the device is awake: `xtalEn`=1, `clkSelXtal`=1, `busReady`=1, `awakeStat`=1 and `voteHeld`=0.
- R2: Deep sleep is entered at the clock edge that completes max(`idleLimit`,1) consecutive awake cycles in which `idleIn`=1, `voteHeld`=0 and `busReq`=0. Any other cycle restarts the count. In sleep, `xtalEn`=0 and `clkSelXtal`=0.
- R3: A cycle in sleep with `busReq`=1 starts power-up. On the next cycle `xtalEn`=1 while `clkSelXtal` is still 0.
- R4: The stabilization phase (`xtalEn`=1, `clkSelXtal`=0) lasts exactly max(`stabLimit`,1) cycles, and `busReady` is 0 throughout.
- R5: After stabilization, `clkSelXtal`=1 for exactly one cycle with `busReady` still 0. Then `busReady` becomes 1. `busReady` is never 1 while `clkSelXtal` is 0.
- R6: `voteSet`=1 makes `voteHeld`=1 from the next cycle. `voteClr`=1 alone makes it 0 from the next cycle. When both are 1, set wins.
- R7: A cycle in sleep with `voteHeld`=1 starts power-up even when `busReq`=0.
- R8: While `voteHeld`=1 the device never enters sleep, whatever `idleIn` does.
- R9: `awakeStat` is 1 exactly in the cycles where the device is awake on the crystal with `busReady`=1.
- R10: A vote set or cleared during stabilization or during the switch cycle neither restarts nor shortens the wake. The idle count starts from zero once the device is awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| idleIn | input | 1 | Device reports nothing to do |
| idleLimit | input | IDLE_W | Consecutive idle cycles needed before sleep |
| stabLimit | input | STAB_W | Crystal stabilization length in cycles |
| voteSet | input | 1 | Host write: hold the device awake |
| voteClr | input | 1 | Host write: release the hold |
| busReq | input | 1 | Host bus transfer pending |
| busReady | output | 1 | Transfer may complete; low stalls the bus |
| xtalEn | output | 1 | Crystal oscillator enable |
| clkSelXtal | output | 1 | Clock select, 1 = crystal, 0 = slow clock |
| awakeStat | output | 1 | Awake on crystal, safe for latency-sensitive access |
| voteHeld | output | 1 | Current state of the vote register |

## Verification
The hardest case to reach is a vote that changes while a wake is already in progress. Examples are a set arriving mid-stabilization, or a clear arriving before the switch cycle. The device has to be asleep first, which takes a long idle stretch with no vote and no request, and the vote edge then has to fall inside a window of only a few cycles. Directed sequences drive the device into sleep with a short idle limit, wake it with a one-cycle request, and pulse the vote at chosen offsets inside stabilization. Random traffic with small limits, changed every few hundred cycles, then reaches many more such overlaps. A cycle-accurate reference model in the bench checks every one of them.

// File: rtl/wvc_pkg.sv
package wvc_pkg;
  typedef enum logic [1:0] {
    PS_AWAKE  = 2'd0,
    PS_SLEEP  = 2'd1,
    PS_STAB   = 2'd2,
    PS_SWITCH = 2'd3
  } pwrState_t;

  typedef struct packed {
    logic idleStep;
    logic stabStep;
  } dpStrobe_t;
endpackage

// File: rtl/wvc_dp.sv
module wvc_dp
  import wvc_pkg::*;
#(
  parameter int IDLE_W = 16,
  parameter int STAB_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [IDLE_W-1:0] idleLimit,
  input  logic [STAB_W-1:0] stabLimit,
  input  logic              voteSet,
  input  logic              voteClr,
  output logic              idleLast,
  output logic              stabLast,
  output logic              voteHeld
);
  localparam int IDLE_XW = IDLE_W + 1;
  localparam int STAB_XW = STAB_W + 1;

  logic [IDLE_W-1:0]  idleCnt;
  logic [STAB_W-1:0]  stabCnt;
  logic [IDLE_XW-1:0] idleNext;
  logic [STAB_XW-1:0] stabNext;

  always_comb begin
    idleNext = {1'b0, idleCnt} + IDLE_XW'(1);
    stabNext = {1'b0, stabCnt} + STAB_XW'(1);
    idleLast = idleNext >= {1'b0, idleLimit};
    stabLast = stabNext >= {1'b0, stabLimit};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt  <= '0;
      stabCnt  <= '0;
      voteHeld <= 1'b0;
    end else begin
      idleCnt <= (strobe.idleStep && !idleLast) ? idleNext[IDLE_W-1:0] : '0;
      stabCnt <= (strobe.stabStep && !stabLast) ? stabNext[STAB_W-1:0] : '0;
      if (voteSet)      voteHeld <= 1'b1;
      else if (voteClr) voteHeld <= 1'b0;
    end
  end
endmodule

// File: rtl/wvc_ctrl.sv
module wvc_ctrl
  import wvc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      idleIn,
  input  logic      busReq,
  input  logic      voteHeld,
  input  logic      idleLast,
  input  logic      stabLast,
  output dpStrobe_t strobe,
  output logic      xtalEn,
  output logic      clkSelXtal,
  output logic      busReady,
  output logic      awakeStat
);
  pwrState_t state, stateNext;
  logic idleQual;

  always_comb begin
    idleQual        = idleIn && !voteHeld && !busReq;
    strobe.idleStep = (state == PS_AWAKE) && idleQual;
    strobe.stabStep = (state == PS_STAB);
    stateNext = state;
    unique case (state)
      PS_AWAKE:  if (strobe.idleStep && idleLast) stateNext = PS_SLEEP;
      PS_SLEEP:  if (busReq || voteHeld)          stateNext = PS_STAB;
      PS_STAB:   if (stabLast)                    stateNext = PS_SWITCH;
      PS_SWITCH:                                  stateNext = PS_AWAKE;
      default:                                    stateNext = PS_AWAKE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= PS_AWAKE;
    else       state <= stateNext;
  end

  always_comb begin
    xtalEn     = (state != PS_SLEEP);
    clkSelXtal = (state == PS_AWAKE) || (state == PS_SWITCH);
    busReady   = (state == PS_AWAKE);
    awakeStat  = (state == PS_AWAKE);
  end
endmodule

// File: rtl/wake_vote_ctrl.sv
module wake_vote_ctrl
  import wvc_pkg::*;
#(
  parameter int IDLE_W = 16,
  parameter int STAB_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              idleIn,
  input  logic [IDLE_W-1:0] idleLimit,
  input  logic [STAB_W-1:0] stabLimit,
  input  logic              voteSet,
  input  logic              voteClr,
  input  logic              busReq,
  output logic              busReady,
  output logic              xtalEn,
  output logic              clkSelXtal,
  output logic              awakeStat,
  output logic              voteHeld
);
  dpStrobe_t strobe;
  logic idleLast, stabLast;

  wvc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .idleIn(idleIn), .busReq(busReq),
    .voteHeld(voteHeld), .idleLast(idleLast), .stabLast(stabLast),
    .strobe(strobe), .xtalEn(xtalEn), .clkSelXtal(clkSelXtal),
    .busReady(busReady), .awakeStat(awakeStat)
  );

  wvc_dp #(.IDLE_W(IDLE_W), .STAB_W(STAB_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .idleLimit(idleLimit),
    .stabLimit(stabLimit), .voteSet(voteSet), .voteClr(voteClr),
    .idleLast(idleLast), .stabLast(stabLast), .voteHeld(voteHeld)
  );
endmodule

// File: rtl/wvc_chk.sv
module wvc_chk (
  input logic clk,
  input logic rstN,
  input logic voteSet,
  input logic voteClr,
  input logic busReq,
  input logic busReady,
  input logic xtalEn,
  input logic clkSelXtal,
  input logic awakeStat,
  input logic voteHeld
);
  AST_SLOW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !xtalEn |-> !clkSelXtal);                                        // R2
  AST_WAKE_START: assert property (@(posedge clk) disable iff (!rstN)
    (!xtalEn && busReq) |=> (xtalEn && !clkSelXtal));               // R3
  AST_READY_ON_XTAL: assert property (@(posedge clk) disable iff (!rstN)
    busReady |-> (clkSelXtal && xtalEn));                            // R5
  AST_SWITCH_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (clkSelXtal && !busReady) |=> busReady);                         // R5
  AST_VOTE_SET: assert property (@(posedge clk) disable iff (!rstN)
    voteSet |=> voteHeld);                                           // R6
  AST_VOTE_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (voteClr && !voteSet) |=> !voteHeld);                            // R6
  AST_VOTE_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (!xtalEn && voteHeld) |=> xtalEn);                               // R7
  AST_NO_SLEEP_VOTE: assert property (@(posedge clk) disable iff (!rstN)
    (voteHeld && xtalEn) |=> xtalEn);                                // R8
  AST_STATUS_READY: assert property (@(posedge clk) disable iff (!rstN)
    awakeStat |-> (busReady && clkSelXtal));                         // R9
endmodule

bind wake_vote_ctrl wvc_chk u_chk (
  .clk(clk), .rstN(rstN), .voteSet(voteSet), .voteClr(voteClr),
  .busReq(busReq), .busReady(busReady), .xtalEn(xtalEn),
  .clkSelXtal(clkSelXtal), .awakeStat(awakeStat), .voteHeld(voteHeld)
);

// File: tb/sim_wake_vote_ctrl.sv
module sim_wake_vote_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 16;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic idleIn = 1'b0, voteSet = 1'b0, voteClr = 1'b0, busReq = 1'b0;
  logic [IW-1:0] idleLimit = '0;
  logic [SW-1:0] stabLimit = '0;
  logic busReady, xtalEn, clkSelXtal, awakeStat, voteHeld;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model: 0 awake, 1 sleep, 2 stabilize, 3 switch
  int mState = 0;
  int mIdle = 0;
  int mStab = 0;
  bit mVote = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_vote_ctrl #(.IDLE_W(IW), .STAB_W(SW)) u0 (
    .clk(clk), .rstN(rstN), .idleIn(idleIn), .idleLimit(idleLimit),
    .stabLimit(stabLimit), .voteSet(voteSet), .voteClr(voteClr),
    .busReq(busReq), .busReady(busReady), .xtalEn(xtalEn),
    .clkSelXtal(clkSelXtal), .awakeStat(awakeStat), .voteHeld(voteHeld)
  );

  function automatic int atLeastOne(input int v);
    return (v < 1) ? 1 : v;
  endfunction
  function automatic bit expXtal();  return mState != 1; endfunction
  function automatic bit expSel();   return (mState == 0) || (mState == 3); endfunction
  function automatic bit expReady(); return mState == 0; endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check("R2", "xtalEn", xtalEn, expXtal());
    check("R5", "clkSelXtal", clkSelXtal, expSel());
    check("R4", "busReady", busReady, expReady());
    check("R9", "awakeStat", awakeStat, expReady());
    check("R6", "voteHeld", voteHeld, mVote);
  endtask

  task automatic modelStep();
    bit qual;
    qual = idleIn && !mVote && !busReq;
    case (mState)
      0: if (qual) begin
           if (mIdle + 1 >= atLeastOne(idleLimit)) begin mState = 1; mIdle = 0; end
           else mIdle++;
         end else mIdle = 0;
      1: if (busReq || mVote) begin mState = 2; mStab = 0; end
      2: if (mStab + 1 >= atLeastOne(stabLimit)) begin mState = 3; mStab = 0; end
         else mStab++;
      default: mState = 0;
    endcase
    if (voteSet) mVote = 1'b1;
    else if (voteClr) mVote = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int wakeLen;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check("R1", "xtalEn", xtalEn, 1);
    check("R1", "clkSelXtal", clkSelXtal, 1);
    check("R1", "busReady", busReady, 1);
    check("R1", "awakeStat", awakeStat, 1);
    check("R1", "voteHeld", voteHeld, 0);

    // R2: exact idle count, with a break restarting it
    idleLimit = 3; stabLimit = 2;
    idleIn = 1'b1; steps(2);
    idleIn = 1'b0; step();
    idleIn = 1'b1; steps(2);
    check("R2", "still awake after restart", xtalEn, 1);
    step();
    check("R2", "asleep xtalEn", xtalEn, 0);
    check("R2", "asleep clkSel", clkSelXtal, 0);

    // R3 R4 R5: access wake
    busReq = 1'b1; step();
    check("R3", "crystal on, slow clock", {xtalEn, clkSelXtal}, 2);
    step();
    check("R4", "ready held in stabilize", busReady, 0);
    step();
    check("R5", "switch cycle", {clkSelXtal, busReady}, 2);
    step();
    check("R5", "ready after switch", busReady, 1);
    busReq = 1'b0;

    // R7 R8: vote wakes and blocks sleep
    steps(3);
    check("R2", "asleep again", xtalEn, 0);
    voteSet = 1'b1; step(); voteSet = 1'b0;
    step();
    check("R7", "vote wakes", xtalEn, 1);
    steps(12);
    check("R8", "no sleep under vote", xtalEn, 1);
    check("R9", "status awake", awakeStat, 1);
    voteClr = 1'b1; voteSet = 1'b1; step(); voteClr = 1'b0; voteSet = 1'b0;
    check("R6", "set wins", voteHeld, 1);
    voteClr = 1'b1; step(); voteClr = 1'b0;
    check("R6", "cleared", voteHeld, 0);
    steps(3);
    check("R8", "sleep after unvote", xtalEn, 0);

    // R10: vote set then cleared inside the wake does not alter its length
    stabLimit = 4;
    idleIn = 1'b0;
    busReq = 1'b1; step(); busReq = 1'b0;
    wakeLen = 1;
    voteSet = 1'b1; step(); voteSet = 1'b0; wakeLen++;
    voteClr = 1'b1; step(); voteClr = 1'b0; wakeLen++;
    while (!busReady && wakeLen < 50) begin step(); wakeLen++; end
    check("R10", "wake length", wakeLen, 4 + 2);
    idleIn = 1'b1; steps(2);
    check("R10", "idle count from zero", xtalEn, 1);
    step();
    check("R10", "sleep after fresh count", xtalEn, 0);

    // R2 boundary: limit zero behaves as one
    idleIn = 1'b0; busReq = 1'b1; stabLimit = 0; steps(3); busReq = 1'b0;
    check("R4", "zero stab limit awake", busReady, 1);
    idleLimit = 0; idleIn = 1'b1; step();
    check("R2", "zero idle limit one cycle", xtalEn, 0);

    // random traffic
    void'($urandom(32'h5eed_0017));
    for (int i = 0; i < 6000; i++) begin
      if (i % 250 == 0) begin
        idleLimit = IW'($urandom_range(0, 6));
        stabLimit = SW'($urandom_range(0, 5));
      end
      idleIn  = ($urandom_range(0, 9) < 8);
      busReq  = ($urandom_range(0, 99) < 6);
      voteSet = ($urandom_range(0, 99) < 3);
      voteClr = ($urandom_range(0, 99) < 6);
      step();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule